// File: doc/BRIEF.md
# Dual-Mode Register/Pass-Through Bus Driver

This block drives a 12-bit data bus. It can present its inputs through an internal edge-triggered register, or it can pass them straight to its outputs with no register in the path. A path-select input chooses between the two. Every data bit leaves the block on two output copies that always carry the same value. An active-low output-enable input switches off all 24 output drivers together. The tri-state condition is modelled as a per-pin drive-enable vector, so no tri-state nets exist inside the block.

The capture register is split into two groups. The low group, bits 7:0, loads only while the active-low capture enable is asserted. The high group, bits 11:8, loads on every rising clock edge. The register keeps loading under the same rules while the pass-through path is selected. When the registered path is selected again, the outputs show the value most recently captured. A synchronous active-high reset clears the register.

Top module: `dual_path_bus_driver`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the capture register becomes all zeros. With `pass_sel` low after that edge, `y1` and `y2` read 0.
- R2: With `pass_sel` low, `y1` and `y2` show the capture register, and the register updates only at the rising edge of `clk`.
- R3: At a rising edge with `cap_en_n` low and `rst` low, the register loads all 12 bits of `a_in`.
- R4: At a rising edge with `cap_en_n` high and `rst` low, register bits 11:8 load from `a_in[11:8]` and bits 7:0 keep their previous value.
- R5: With `pass_sel` high, `y1` and `y2` equal `a_in` in the same cycle, with no clock edge needed.
- R6: The register keeps loading under the R3/R4 rules while `pass_sel` is high. When `pass_sel` returns low, the outputs show the value captured at the most recent edge.
- R7: `y1` and `y2` carry identical values at all times.
- R8: Bit i of `y_oe` enables `y1[i]`, and bit 12+i enables `y2[i]`. With `out_en_n` high, all 24 bits of `y_oe` are 0 whatever `pass_sel`, `cap_en_n` or `clk` do. With `out_en_n` low, all 24 bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the capture register |
| a_in | input | 12 | Input data bus |
| cap_en_n | input | 1 | Active-low capture enable for bits 7:0 |
| pass_sel | input | 1 | 0 = registered path, 1 = pass-through path |
| out_en_n | input | 1 | Active-low enable for all output drivers |
| y1 | output | 12 | First output copy |
| y2 | output | 12 | Second output copy |
| y_oe | output | 24 | Per-pin drive enables: bits 11:0 for `y1`, bits 23:12 for `y2` |

## Verification
The assertions check several rules on every cycle: the group-wise load rules of the capture register (full load, low-group hold, high-group load), the clear on reset, the equality of the two copies, the pass-through equality, and the all-or-nothing drive enables. Some behaviour only the bench's scenarios can show. One is that the register keeps loading while the pass-through path is selected, so that returning to the registered path exposes a specific earlier capture. The other is the exact cycle in which a captured value first appears at the outputs, across mixed sequences of capture-enable and path-select changes.

// File: rtl/bus_drv_pkg.sv
package bus_drv_pkg;

    typedef enum logic {
        PATH_REG  = 1'b0,
        PATH_PASS = 1'b1
    } path_e;

endpackage

// File: rtl/bus_drv_capture.sv
module bus_drv_capture #(
    parameter int WIDTH    = 12,
    parameter int LOW_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_low,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < LOW_BITS) begin : g_gated
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[i] <= 1'b0;
                end else if (!hold_low) begin
                    q[i] <= d[i];
                end
            end
        end else begin : g_free
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[i] <= 1'b0;
                end else begin
                    q[i] <= d[i];
                end
            end
        end
    end

endmodule

// File: rtl/bus_drv_select.sv
module bus_drv_select
    import bus_drv_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  path_e            path,
    input  logic [WIDTH-1:0] reg_q,
    input  logic [WIDTH-1:0] live,
    output logic [WIDTH-1:0] data
);

    always_comb begin
        unique case (path)
            PATH_REG:  data = reg_q;
            PATH_PASS: data = live;
            default:   data = reg_q;
        endcase
    end

endmodule

// File: rtl/bus_drv_fanout.sv
module bus_drv_fanout #(
    parameter int WIDTH  = 12,
    parameter int COPIES = 2
) (
    input  logic                          drive_on,
    input  logic [WIDTH-1:0]              data,
    output logic [COPIES-1:0][WIDTH-1:0]  copy,
    output logic [COPIES*WIDTH-1:0]       pin_en
);

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign copy[c]                     = data;
        assign pin_en[c*WIDTH +: WIDTH]    = {WIDTH{drive_on}};
    end

endmodule

// File: rtl/dual_path_bus_driver.sv
module dual_path_bus_driver
    import bus_drv_pkg::*;
#(
    parameter int WIDTH    = 12,
    parameter int LOW_BITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   a_in,
    input  logic               cap_en_n,
    input  logic               pass_sel,
    input  logic               out_en_n,
    output logic [WIDTH-1:0]   y1,
    output logic [WIDTH-1:0]   y2,
    output logic [2*WIDTH-1:0] y_oe
);

    localparam int COPIES = 2;

    logic [WIDTH-1:0]             cap_q;
    logic [WIDTH-1:0]             sel_data;
    logic [COPIES-1:0][WIDTH-1:0] copies;
    path_e                        path;

    assign path = path_e'(pass_sel);

    bus_drv_capture #(
        .WIDTH    (WIDTH),
        .LOW_BITS (LOW_BITS)
    ) cap_i (
        .clk      (clk),
        .rst      (rst),
        .hold_low (cap_en_n),
        .d        (a_in),
        .q        (cap_q)
    );

    bus_drv_select #(
        .WIDTH (WIDTH)
    ) sel_i (
        .path  (path),
        .reg_q (cap_q),
        .live  (a_in),
        .data  (sel_data)
    );

    bus_drv_fanout #(
        .WIDTH  (WIDTH),
        .COPIES (COPIES)
    ) fan_i (
        .drive_on (~out_en_n),
        .data     (sel_data),
        .copy     (copies),
        .pin_en   (y_oe)
    );

    assign y1 = copies[0];
    assign y2 = copies[1];

endmodule

// File: rtl/bus_drv_checker.sv
module bus_drv_checker #(
    parameter int WIDTH    = 12,
    parameter int LOW_BITS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [WIDTH-1:0]   a_in,
    input logic               cap_en_n,
    input logic               pass_sel,
    input logic               out_en_n,
    input logic [WIDTH-1:0]   y1,
    input logic [WIDTH-1:0]   y2,
    input logic [2*WIDTH-1:0] y_oe,
    input logic [WIDTH-1:0]   cap_q
);

    // R1: the reset edge clears the register
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cap_q == '0));

    // R3: full load while the capture enable is asserted
    a_r3_full_load: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cap_en_n) |=> (cap_q == $past(a_in)));

    // R4: the low group holds while the capture enable is off
    a_r4_low_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && cap_en_n) |=> $stable(cap_q[LOW_BITS-1:0]));

    // R4: the high group loads on every edge
    a_r4_high_load: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cap_q[WIDTH-1:LOW_BITS] == $past(a_in[WIDTH-1:LOW_BITS])));

    // R2: the registered path shows the register
    a_r2_reg_path: assert property (@(posedge clk) disable iff (rst)
        !pass_sel |-> (y1 == cap_q));

    // R5: the pass-through path follows the inputs
    a_r5_pass_path: assert property (@(posedge clk) disable iff (rst)
        pass_sel |-> (y1 == a_in));

    // R7: the two copies match
    a_r7_copies_match: assert property (@(posedge clk) disable iff (rst)
        y1 == y2);

    // R8: the drivers switch on and off together
    a_r8_drive_off: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (y_oe == '0));

    a_r8_drive_on: assert property (@(posedge clk) disable iff (rst)
        !out_en_n |-> (&y_oe));

endmodule

bind dual_path_bus_driver bus_drv_checker #(
    .WIDTH    (WIDTH),
    .LOW_BITS (LOW_BITS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .cap_en_n (cap_en_n),
    .pass_sel (pass_sel),
    .out_en_n (out_en_n),
    .y1       (y1),
    .y2       (y2),
    .y_oe     (y_oe),
    .cap_q    (cap_q)
);

// File: tb/dual_path_bus_driver_tb.sv
module dual_path_bus_driver_tb_top;

    localparam int W  = 12;
    localparam int LB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a_in = '0;
    logic          cap_en_n = 1'b0;
    logic          pass_sel = 1'b0;
    logic          out_en_n = 1'b0;
    logic [W-1:0]  y1;
    logic [W-1:0]  y2;
    logic [2*W-1:0] y_oe;

    always #5 clk = ~clk;

    dual_path_bus_driver #(.WIDTH(W), .LOW_BITS(LB)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .cap_en_n (cap_en_n),
        .pass_sel (pass_sel),
        .out_en_n (out_en_n),
        .y1       (y1),
        .y2       (y2),
        .y_oe     (y_oe)
    );

    typedef struct {
        logic [W-1:0]   ey;
        logic [2*W-1:0] eoe;
        string          tag;
    } exp_t;

    exp_t   sb_q[$];
    exp_t   mon_item;
    event   sample_ev;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    logic [W-1:0] model_q = '0;

    // monitor: pops expected items and compares with the outputs
    always @(sample_ev) begin
        while (sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            n_cmp++;
            if (y1 !== mon_item.ey || y2 !== mon_item.ey || y_oe !== mon_item.eoe) begin
                n_bad++;
                $display("FAIL %s: y1=%h y2=%h y_oe=%h expected y=%h y_oe=%h",
                         mon_item.tag, y1, y2, y_oe, mon_item.ey, mon_item.eoe);
            end
        end
    end

    // driver: one cycle of stimulus, optional expectation, model update at the edge
    task automatic step(input logic r, input logic [W-1:0] a, input logic cen,
                        input logic mode, input logic oen, input bit chk, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; a_in = a; cap_en_n = cen; pass_sel = mode; out_en_n = oen;
        #1;
        if (chk) begin
            it.ey  = mode ? a : model_q;
            it.eoe = oen ? '0 : '1;
            it.tag = tag;
            sb_q.push_back(it);
            -> sample_ev;
            #1;
        end
        @(posedge clk);
        if (r) model_q = '0;
        else begin
            model_q[W-1:LB] = a[W-1:LB];
            if (!cen) model_q[LB-1:0] = a[LB-1:0];
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset clears the register
        step(1'b1, 12'hFFF, 1'b0, 1'b0, 1'b0, 0, "R1");
        step(1'b1, 12'hFFF, 1'b0, 1'b0, 1'b0, 0, "R1");
        step(1'b0, 12'hABC, 1'b0, 1'b0, 1'b0, 1, "R1 cleared");
        // R2/R3: full capture shows one edge later
        step(1'b0, 12'h123, 1'b1, 1'b0, 1'b0, 1, "R2 R3 full load visible");
        // R4: only high group loaded from 123
        step(1'b0, 12'h777, 1'b0, 1'b0, 1'b0, 1, "R4 low hold");
        step(1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1, "R3 full load");
        step(1'b0, 12'hFFF, 1'b1, 1'b0, 1'b0, 1, "R4 high only");
        step(1'b0, 12'h5A5, 1'b0, 1'b0, 1'b0, 1, "R4 high only again");
        // R5: pass-through, register keeps loading (R6)
        step(1'b0, 12'h5A5, 1'b0, 1'b1, 1'b0, 1, "R5 pass");
        step(1'b0, 12'h0F0, 1'b1, 1'b1, 1'b0, 1, "R5 pass second");
        step(1'b0, 12'h3C3, 1'b1, 1'b0, 1'b0, 1, "R6 return to register");
        // R8: drivers off in both paths
        step(1'b0, 12'h9E1, 1'b0, 1'b0, 1'b1, 1, "R8 off reg path");
        step(1'b0, 12'h246, 1'b1, 1'b1, 1'b1, 1, "R8 off pass path");
        step(1'b0, 12'h246, 1'b1, 1'b0, 1'b0, 1, "R8 on again");
        // R7: copies compared in every item; mixed patterns
        for (int i = 0; i < 40; i++) begin
            step(1'b0, W'((i * 12'h2D7) ^ (i << 5)), i[0], i[2], i[3] & i[1], 1, "R7 R3 R4 mixed");
        end
        // R1: reset after activity
        step(1'b1, 12'hAAA, 1'b0, 1'b0, 1'b0, 0, "R1");
        step(1'b0, 12'h555, 1'b1, 1'b0, 1'b0, 1, "R1 cleared again");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule